// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block runs the entry sequence of an 8-bit processor core. The sequence starts on one of four events: a reset request, a non-maskable interrupt, a maskable interrupt, or the software break instruction. The core's decoder and ALU sit outside the block. The block takes the current program counter, stack pointer and status byte, and saves the return context on a stack held in one fixed memory page. It then reads a 16-bit vector from a fixed address and hands back the new program counter, stack pointer and status.

Each request is held as pending until it is serviced. When several requests are pending, they are served one after another by fixed priority. A maskable interrupt that arrives while the interrupt-disable flag is set still takes its full time slot, but it leaves all state unchanged. Memory is a plain synchronous port: a write takes effect at the clock edge, and read data is returned on the cycle after the address is driven. When the new context is valid, a done strobe is raised together with the number of cycles the entry took.

Top module: `cpu_entry_seq`

## Requirements
- R1: The new program counter is taken from a vector at fixed addresses, with the low byte at the lower address. The addresses are 0xFFFA/0xFFFB for the non-maskable interrupt, 0xFFFC/0xFFFD for reset, and 0xFFFE/0xFFFF for both the maskable interrupt and the break instruction.
- R2: Pending requests are served in the order reset, then non-maskable interrupt, then maskable interrupt, then break. Serving a request clears its pending flag, so each pulse is served exactly once.
- R3: If a maskable interrupt is served while status bit 2 (interrupt disable) is set, it still takes 7 cycles. It makes no memory write and leaves the program counter, stack pointer and status unchanged.
- R4: A hardware or break entry makes three writes: PC[15:8], then PC[7:0], then the status byte. Each write goes to address 0x0100+S, and S is decremented after each write, so S ends 3 lower (wrapping modulo 256).
- R5: The status byte pushed on a stack has bit 4 clear for both interrupt types and bit 4 set for the break instruction. A break entry pushes PC+1 (wrapping modulo 65536) in place of PC.
- R6: After a non-maskable, maskable or break entry, the status output equals the pushed status byte with bit 2 (interrupt disable) set.
- R7: A reset entry makes no memory write. It sets S to 0xFF, sets status bits 2 and 1 (interrupt disable and zero), keeps the other status bits, and loads the program counter from the reset vector.
- R8: A reset entry takes 6 cycles and every other entry takes 7. The busy output is high for exactly that many cycles, and the cycle count is presented with the done strobe.
- R9: Status bit 5 reads as 1 at the status output and in every pushed status byte, whatever the input value.
- R10: A request that arrives while an entry is in progress is held and served after that entry ends. The done strobe lasts exactly one cycle, and it rises when the new program counter is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_reset | input | 1 | Reset entry request, latched while high |
| req_nmi | input | 1 | Non-maskable interrupt request, latched while high |
| req_irq | input | 1 | Maskable interrupt request, latched while high |
| brk_go | input | 1 | Break instruction entry strobe, latched while high |
| pc_in | input | 16 | Current program counter, sampled when an entry starts |
| sp_in | input | 8 | Current stack pointer, sampled when an entry starts |
| st_in | input | 8 | Current status byte (bit 0 C, 1 Z, 2 I, 3 D, 4 B, 6 V, 7 N) |
| mem_rdata | input | 8 | Read data, valid the cycle after the address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| pc_out | output | 16 | Program counter after entry |
| sp_out | output | 8 | Stack pointer after entry |
| st_out | output | 8 | Status byte after entry |
| busy | output | 1 | An entry sequence is in progress |
| done | output | 1 | One-cycle strobe: the outputs hold the new context |
| cycles | output | 4 | Cycles used by the entry just finished |

## Verification
The bench builds the block with its default parameters: stack page 0x01, the three fixed vector bases and a 4-bit cycle counter. The memory model returns bytes that are a function of the address and of a seed that changes per run, so each vector read is traced back to its address. Every source is swept against both values of the interrupt-disable flag and six context patterns. These patterns include stack pointers 0x00 to 0x02, where the three pushes wrap, and a program counter of 0xFFFF, where the break increment wraps. Further runs pulse several sources in one cycle, and one run raises a request in the middle of an entry, to check priority order and latching.

// File: rtl/cpu_entry_pkg.sv
package cpu_entry_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int NSRC   = 4;

  // Source index is also the priority: lower index wins.
  typedef enum logic [1:0] {
    SRC_RST = 2'd0,
    SRC_NMI = 2'd1,
    SRC_IRQ = 2'd2,
    SRC_BRK = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PICK,
    SQ_PUSH_H,
    SQ_PUSH_L,
    SQ_PUSH_P,
    SQ_VEC_L,
    SQ_VEC_H,
    SQ_LOAD
  } seq_e;

  // Status bit positions
  localparam int FL_Z   = 1;
  localparam int FL_I   = 2;
  localparam int FL_B   = 4;
  localparam int FL_ONE = 5;
endpackage

// File: rtl/entry_arbiter.sv
module entry_arbiter
  import cpu_entry_pkg::*;
#(
  parameter int N  = NSRC,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          any_pend,
  output logic [SW-1:0] sel
);
  logic [N-1:0] pend_q, pend_d, clr;

  // Lowest set index has the highest priority.
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = SW'(i);
    end
  end

  always_comb begin
    clr = '0;
    if (take) clr[sel] = 1'b1;
    pend_d = (pend_q & ~clr) | req;
  end

  assign any_pend = |pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R2: a served request leaves the pending set
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req == '0) |=> ($countones(pend_q) + 1) == $countones($past(pend_q)));

  // R2: the non-maskable request is never passed over by a lower one
  p_nmi_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pend_q[SRC_NMI]) |-> (sel <= SW'(SRC_NMI)));
endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
  import cpu_entry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend,
  input  logic is_rst,
  output seq_e state,
  output logic take,
  output logic busy
);
  seq_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    take = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (any_pend) begin
          take = 1'b1;
          st_d = SQ_PICK;
        end
      end
      SQ_PICK:   st_d = is_rst ? SQ_PUSH_L : SQ_PUSH_H;
      SQ_PUSH_H: st_d = SQ_PUSH_L;
      SQ_PUSH_L: st_d = SQ_PUSH_P;
      SQ_PUSH_P: st_d = SQ_VEC_L;
      SQ_VEC_L:  st_d = SQ_VEC_H;
      SQ_VEC_H:  st_d = SQ_LOAD;
      SQ_LOAD:   st_d = SQ_IDLE;
      default:   st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
  assign busy  = (st_q != SQ_IDLE);

  // R8: the reset path skips exactly the high-byte slot
  p_rst_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_PICK && is_rst) |=> st_q == SQ_PUSH_L);
endmodule

// File: rtl/entry_datapath.sv
module entry_datapath
  import cpu_entry_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_RST    = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE,
  parameter int          CNT_W      = 4,
  localparam logic [CNT_W-1:0] CYC_RST = CNT_W'(6),
  localparam logic [CNT_W-1:0] CYC_INT = CNT_W'(7)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_e              state,
  input  logic              take,
  input  src_e              sel,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] st_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              is_rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] sp_out,
  output logic [DATA_W-1:0] st_out,
  output logic              done,
  output logic [CNT_W-1:0]  cycles
);
  src_e              src_q, src_d;
  logic              skip_q, skip_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] sp_q, sp_d, st_q, st_d, lo_q, lo_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cost_q, cost_d;

  logic              hw_push, brk_now, brk_sel;
  logic [ADDR_W-1:0] vec_base;
  logic [DATA_W-1:0] push_st;

  assign is_rst   = (src_q == SRC_RST);
  assign brk_now  = (src_q == SRC_BRK);
  assign brk_sel  = (sel == SRC_BRK);
  assign hw_push  = !is_rst && !skip_q;
  assign vec_base = (src_q == SRC_NMI) ? VEC_NMI :
                    (src_q == SRC_RST) ? VEC_RST : VEC_IRQ;
  assign push_st  = {st_q[7:6], 1'b1, brk_now, st_q[3:0]};

  // Memory port
  always_comb begin
    mem_addr  = {STACK_PAGE, sp_q};
    mem_wdata = '0;
    mem_we    = 1'b0;
    unique case (state)
      SQ_PUSH_H: begin mem_we = hw_push; mem_wdata = pc_q[15:8]; end
      SQ_PUSH_L: begin mem_we = hw_push; mem_wdata = pc_q[7:0];  end
      SQ_PUSH_P: begin mem_we = hw_push; mem_wdata = push_st;    end
      SQ_VEC_L:  mem_addr = vec_base;
      SQ_VEC_H:  mem_addr = vec_base + 16'd1;
      default:   mem_addr = {STACK_PAGE, sp_q};
    endcase
  end

  // Next-state of the context registers
  always_comb begin
    src_d  = src_q;
    skip_d = skip_q;
    pc_d   = pc_q;
    sp_d   = sp_q;
    st_d   = st_q;
    lo_d   = lo_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    cost_d = cost_q;
    if (take) begin
      src_d  = sel;
      skip_d = (sel == SRC_IRQ) && st_in[FL_I];
      pc_d   = pc_in + {{(ADDR_W-1){1'b0}}, brk_sel};
      sp_d   = sp_in;
      st_d   = st_in | (8'h01 << FL_ONE);
      cnt_d  = CNT_W'(1);
    end else if (state != SQ_IDLE) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (mem_we) sp_d = sp_q - 8'd1;
      if (state == SQ_VEC_H) lo_d = mem_rdata;
      if (state == SQ_LOAD) begin
        done_d = 1'b1;
        cost_d = cnt_q;
        if (is_rst) begin
          pc_d = {mem_rdata, lo_q};
          sp_d = 8'hFF;
          st_d = st_q | (8'h01 << FL_I) | (8'h01 << FL_Z);
        end else if (!skip_q) begin
          pc_d = {mem_rdata, lo_q};
          st_d = push_st | (8'h01 << FL_I);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_RST;
      skip_q <= 1'b0;
      pc_q   <= '0;
      sp_q   <= '0;
      st_q   <= 8'h20;
      lo_q   <= '0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      cost_q <= '0;
    end else begin
      src_q  <= src_d;
      skip_q <= skip_d;
      pc_q   <= pc_d;
      sp_q   <= sp_d;
      st_q   <= st_d;
      lo_q   <= lo_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      cost_q <= cost_d;
    end
  end

  assign pc_out = pc_q;
  assign sp_out = sp_q;
  assign st_out = st_q;
  assign done   = done_q;
  assign cycles = cost_q;

  p_stack_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == STACK_PAGE);

  p_sp_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_q == $past(sp_q) - 8'd1);

  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && state != SQ_IDLE) |-> !mem_we);

  p_masked_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && state != SQ_IDLE) |=> $stable(pc_q));

  p_rst_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rst && state != SQ_IDLE) |-> !mem_we);

  p_rst_ctx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && is_rst) |-> (sp_q == 8'hFF && st_q[FL_I] && st_q[FL_Z]));

  p_cost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> cost_q == (is_rst ? CYC_RST : CYC_INT));

  p_bit5_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[FL_ONE] && (!(mem_we && state == SQ_PUSH_P) || mem_wdata[FL_ONE]));

  p_pushed_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && state == SQ_PUSH_P) |-> mem_wdata[FL_B] == brk_now);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/cpu_entry_seq.sv
module cpu_entry_seq
  import cpu_entry_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_RST    = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE,
  parameter int          CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_reset,
  input  logic              req_nmi,
  input  logic              req_irq,
  input  logic              brk_go,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] st_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] sp_out,
  output logic [DATA_W-1:0] st_out,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  cycles
);
  // Reset: asserted asynchronously, released on the clock
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic [NSRC-1:0] req_vec;
  logic [1:0]      sel_idx;
  logic            any_pend, take, is_rst;
  seq_e            state;

  // Index order equals priority order (src_e)
  assign req_vec = {brk_go, req_irq, req_nmi, req_reset};

  entry_arbiter #(.N(NSRC)) u_arb (
    .clk      (clk),
    .rst_n    (rs_n),
    .req      (req_vec),
    .take     (take),
    .any_pend (any_pend),
    .sel      (sel_idx)
  );

  entry_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rs_n),
    .any_pend (any_pend),
    .is_rst   (is_rst),
    .state    (state),
    .take     (take),
    .busy     (busy)
  );

  entry_datapath #(
    .STACK_PAGE (STACK_PAGE),
    .VEC_NMI    (VEC_NMI),
    .VEC_RST    (VEC_RST),
    .VEC_IRQ    (VEC_IRQ),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rs_n),
    .state     (state),
    .take      (take),
    .sel       (src_e'(sel_idx)),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .st_in     (st_in),
    .mem_rdata (mem_rdata),
    .is_rst    (is_rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .pc_out    (pc_out),
    .sp_out    (sp_out),
    .st_out    (st_out),
    .done      (done),
    .cycles    (cycles)
  );
endmodule

// File: tb/cpu_entry_seq_test.sv
`timescale 1ns/1ps
module cpu_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_reset, req_nmi, req_irq, brk_go;
  logic [15:0] pc_in;
  logic [7:0]  sp_in, st_in, mem_rdata;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, sp_out, st_out;
  logic        mem_we, busy, done;
  logic [3:0]  cycles;

  always #2 clk = ~clk;   // 250 MHz

  cpu_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .req_reset(req_reset), .req_nmi(req_nmi),
    .req_irq(req_irq), .brk_go(brk_go), .pc_in(pc_in), .sp_in(sp_in),
    .st_in(st_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .pc_out(pc_out),
    .sp_out(sp_out), .st_out(st_out), .busy(busy), .done(done),
    .cycles(cycles)
  );

  // Memory model: read byte is a function of address and seed
  logic [7:0]  seed;
  logic [15:0] wa [0:1023];
  logic [7:0]  wd [0:1023];
  logic [9:0]  wn = '0;

  function automatic logic [7:0] rb(input logic [15:0] a, input logic [7:0] s);
    return a[7:0] ^ {a[3:0], a[7:4]} ^ s ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    mem_rdata <= rb(mem_addr, seed);
    if (mem_we) begin
      wa[wn] <= mem_addr;
      wd[wn] <= mem_wdata;
      wn     <= wn + 10'd1;
    end
  end

  int nchk = 0;
  int nerr = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    {brk_go, req_irq, req_nmi, req_reset} = m;
    @(negedge clk);
    {brk_go, req_irq, req_nmi, req_reset} = '0;
  endtask

  task automatic wait_done(output int bn);
    bit got = 0;
    bn = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
      if (busy) bn++;
    end
    check("R10 done seen", {31'd0, got}, 32'd1);
  endtask

  // src: 0 reset, 1 nmi, 2 irq, 3 brk
  task automatic check_entry(input int src, input logic [15:0] pc, input logic [7:0] sp,
                             input logic [7:0] st, input int bn, input bit use_bn,
                             inout logic [9:0] wb);
    logic [15:0] v, vpc, pp;
    logic [7:0]  ps;
    int          nw;
    bit          masked;
    v = (src == 0) ? 16'hFFFC : (src == 1) ? 16'hFFFA : 16'hFFFE;
    vpc = {rb(v + 16'd1, seed), rb(v, seed)};
    masked = (src == 2) && st[2];
    if (src == 0) begin
      nw = 0;
      check("R1 reset vector pc", {16'd0, pc_out}, {16'd0, vpc});
      check("R7 reset sp", {24'd0, sp_out}, 32'hFF);
      check("R7 reset status", {24'd0, st_out}, {24'd0, st | 8'h26});
      check("R8 reset cycles", {28'd0, cycles}, 32'd6);
      if (use_bn) check("R8 reset busy", bn, 6);
    end else if (masked) begin
      nw = 0;
      check("R3 masked pc", {16'd0, pc_out}, {16'd0, pc});
      check("R3 masked sp", {24'd0, sp_out}, {24'd0, sp});
      check("R3 masked status", {24'd0, st_out}, {24'd0, st | 8'h20});
      check("R8 masked cycles", {28'd0, cycles}, 32'd7);
      if (use_bn) check("R3 masked busy", bn, 7);
    end else begin
      nw = 3;
      pp = pc + ((src == 3) ? 16'd1 : 16'd0);
      ps = ((st | 8'h20) & 8'hEF) | ((src == 3) ? 8'h10 : 8'h00);
      check("R1 vector pc", {16'd0, pc_out}, {16'd0, vpc});
      check("R4 sp after push", {24'd0, sp_out}, {24'd0, sp - 8'd3});
      check("R6 status out", {24'd0, st_out}, {24'd0, ps | 8'h04});
      check("R9 status bit5", {31'd0, st_out[5]}, 32'd1);
      check("R8 cycles", {28'd0, cycles}, 32'd7);
      if (use_bn) check("R8 busy", bn, 7);
    end
    check("R4 write count", {22'd0, wn - wb}, nw);
    if (nw == 3) begin
      check("R4 addr hi", {16'd0, wa[wb]}, {16'd0, 8'h01, sp});
      check("R5 data hi", {24'd0, wd[wb]}, {24'd0, pp[15:8]});
      check("R4 addr lo", {16'd0, wa[wb + 10'd1]}, {16'd0, 8'h01, sp - 8'd1});
      check("R5 data lo", {24'd0, wd[wb + 10'd1]}, {24'd0, pp[7:0]});
      check("R4 addr st", {16'd0, wa[wb + 10'd2]}, {16'd0, 8'h01, sp - 8'd2});
      check("R5 pushed status", {24'd0, wd[wb + 10'd2]}, {24'd0, ps});
    end
    wb = wb + 10'(nw);
  endtask

  task automatic run_one(input int src, input logic [15:0] pc, input logic [7:0] sp,
                         input logic [7:0] st, input logic [7:0] sd);
    int bn;
    logic [9:0] wb;
    @(negedge clk);
    seed = sd; pc_in = pc; sp_in = sp; st_in = st; wb = wn;
    pulse(4'(1 << src));
    wait_done(bn);
    check_entry(src, pc, sp, st, bn, 1'b1, wb);
    @(negedge clk);
    check("R10 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic run_all();
    int bn;
    logic [9:0] wb;
    logic [15:0] pc;
    logic [7:0] sp, st;
    // Reset state
    check("R9 reset state status", {24'd0, st_out}, 32'h20);
    check("R10 reset state done", {31'd0, done}, 32'd0);
    check("R8 reset state busy", {31'd0, busy}, 32'd0);
    check("R4 reset state we", {31'd0, mem_we}, 32'd0);
    // Sweep: source x I flag x context pattern
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 2; i++) begin
        for (int k = 0; k < 6; k++) begin
          case (k)
            0: begin pc = 16'h0000; sp = 8'h00; end
            1: begin pc = 16'h1234; sp = 8'h01; end
            2: begin pc = 16'hFFFF; sp = 8'h02; end
            3: begin pc = 16'h80FF; sp = 8'hFF; end
            4: begin pc = 16'hABCD; sp = 8'h80; end
            default: begin pc = 16'h00FE; sp = 8'h37; end
          endcase
          st = ((8'(k) * 8'h4B) & 8'hFB) | (i[0] ? 8'h04 : 8'h00);
          run_one(s, pc, sp, st, 8'(s * 61 + k * 17 + i));
        end
      end
    end
    // R2: three sources in one cycle, I clear -> nmi, irq, brk
    @(negedge clk);
    seed = 8'h5A; pc_in = 16'h4321; sp_in = 8'hC0; st_in = 8'h91; wb = wn;
    pulse(4'b1110);
    wait_done(bn); check_entry(1, 16'h4321, 8'hC0, 8'h91, bn, 1'b1, wb);
    wait_done(bn); check_entry(2, 16'h4321, 8'hC0, 8'h91, bn, 1'b1, wb);
    wait_done(bn); check_entry(3, 16'h4321, 8'hC0, 8'h91, bn, 1'b1, wb);
    check("R2 three entries served once", {31'd0, busy}, 32'd0);
    // R2: reset beats nmi
    @(negedge clk);
    wb = wn;
    pulse(4'b0011);
    wait_done(bn); check_entry(0, 16'h4321, 8'hC0, 8'h91, bn, 1'b1, wb);
    wait_done(bn); check_entry(1, 16'h4321, 8'hC0, 8'h91, bn, 1'b1, wb);
    // R2/R3: masked irq before brk, I set
    @(negedge clk);
    st_in = 8'h04; wb = wn;
    pulse(4'b1100);
    wait_done(bn); check_entry(2, 16'h4321, 8'hC0, 8'h04, bn, 1'b1, wb);
    wait_done(bn); check_entry(3, 16'h4321, 8'hC0, 8'h04, bn, 1'b1, wb);
    // R10: nmi raised mid-entry waits for the irq to finish
    @(negedge clk);
    st_in = 8'h00; seed = 8'hC3; wb = wn;
    pulse(4'b0100);
    @(negedge clk);
    @(negedge clk);
    pulse(4'b0010);
    wait_done(bn); check_entry(2, 16'h4321, 8'hC0, 8'h00, bn, 1'b0, wb);
    wait_done(bn); check_entry(1, 16'h4321, 8'hC0, 8'h00, bn, 1'b1, wb);
    repeat (3) @(negedge clk);
    check("R10 no spurious entry", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    {brk_go, req_irq, req_nmi, req_reset} = '0;
    pc_in = '0; sp_in = '0; st_in = '0; seed = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R10 watchdog expired actual=hung expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule